// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that reads and writes PHY registers over the two-wire MDC/MDIO serial interface. It supports both the 1G framing (Clause 22) and the extended framing (Clause 45). A host writes four 32-bit registers through a simple word-addressed write port. Read data is returned combinationally for the addressed word. Writing particular fields starts one serial frame. While the frame runs, the block divides the system clock down to MDC, shifts the frame out, releases MDIO for the target's reply, samples it, and reports busy and error status.

A Clause 45 access is built from two separate frames. The first is an address frame, started by a write to the address register. The second is a write or read frame, started by a write to the data register or by setting the read bit in the control register. A Clause 22 access needs only the second frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Registers sit at word offsets 12 (status), 13 (control), 14 (data) and 15 (address). All other offsets read as zero. All registers read zero after reset.
  - Status layout: bit 0 = busy, bit 1 = read error, bit 6 = extended framing (1 selects Clause 45), bits 15:8 = divider.
  - Control layout: bits 4:0 = device/register field, bits 9:5 = PHY port, bit 10 = preamble off, bit 11 = scan flag, bit 14 = post-increment flag, bit 15 = start read (reads back as 0).
  - The flags are stored and read back, and start no frame.
- R2: MDC idles low. During a frame, MDC toggles every max(divider,1) clock cycles. The first rise comes max(divider,1) cycles after the clock edge that accepts the starting write.
- R3: A write to the data register in Clause 22 mode sends a write frame: 32 ones, then start 01, opcode 01, port, register, turnaround 10, and 16 data bits. All fields are sent MSB first.
- R4: A control write with bit 15 set starts a read frame (Clause 22 opcode 10).
  - The master drives MDIO through the port and device fields.
  - It releases MDIO (output enable low) for both turnaround bits and the 16 data bits.
  - It captures the data sampled at MDC rises into the data register.
  - MDIO output enable is low whenever the block is idle.
- R5: In Clause 45 mode, a write to the address register sends an address frame: start 00, opcode 00, port, device, turnaround 10, and the 16-bit address. In Clause 22 mode the same write is only stored and starts no frame.
- R6: In Clause 45 mode, data writes use start 00 with opcode 01, and reads use start 00 with opcode 11.
- R7: With preamble off, a frame is 32 bits long with no leading ones.
- R8: If MDIO is sampled high on the second turnaround bit of a read, the read-error status bit is set and the data register reads 0xFFFF. A later good read clears the error.
- R9: Status bit 0 is high for the whole of any frame. Data register bit 31 is high during write and read frames only, not during address frames.
- R10: Register writes that arrive while a frame is in progress are ignored: the frame on the wire and the stored data are unchanged.
- R11: While the master drives MDIO, the output changes only on a falling edge of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A reference model predicts MDC, output enable, the driven bit and busy on every clock of each frame. It is run under these cases:
- Divider values of 0, 2 and 3, which separate the half-period rule from a plain divide-by-divider.
- Each framing and opcode combination: Clause 22 write and read, Clause 45 address, write and read. Mismatched start or opcode bits show up at one exact bit position.
- Preamble on and off, which tells a 64-bit frame from a 32-bit one.
- A read whose second turnaround bit stays high, followed by a good read, so that error setting and error clearing are told apart.
- A data write injected mid-frame, and an address write in Clause 22 mode. Both must leave the wire and the registers untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DIV_W   = 8;
    localparam int DAT_W   = 16;
    localparam int FLD_W   = 5;
    localparam int FRM_W   = 2 + 2 + 2*FLD_W + 2 + DAT_W;   // 32 bit frame body
    localparam int PRE_LEN = FRM_W;                         // preamble equals body length
    localparam int BCNT_W  = $clog2(FRM_W + PRE_LEN);
    localparam int POS_W   = $clog2(FRM_W);
    localparam int TA_HI   = DAT_W + 1;
    localparam int TA_LO   = DAT_W;
    localparam int BADR_W  = 4;

    localparam logic [BADR_W-1:0] OFS_STAT = 4'd12;
    localparam logic [BADR_W-1:0] OFS_CTRL = 4'd13;
    localparam logic [BADR_W-1:0] OFS_DATA = 4'd14;
    localparam logic [BADR_W-1:0] OFS_ADDR = 4'd15;

    typedef enum logic [1:0] {
        K_ADDR  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               c45;
        logic               no_pre;
        logic [FLD_W-1:0]   port;
        logic [FLD_W-1:0]   dev;
        logic [DAT_W-1:0]   data;
    } cmd_t;

    // Assemble start, opcode, port, device, turnaround and payload.
    function automatic logic [FRM_W-1:0] build_frame(cmd_t c);
        logic [1:0] st;
        logic [1:0] op;
        st = c.c45 ? 2'b00 : 2'b01;
        unique case (c.kind)
            K_ADDR:  op = 2'b00;
            K_WRITE: op = 2'b01;
            default: op = c.c45 ? 2'b11 : 2'b10;
        endcase
        return {st, op, c.port, c.dev, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic             tick;

    assign half      = (div == '0) ? DIV_W'(1) : div;
    assign tick      = run && (cnt == half - DIV_W'(1));
    assign rise_tick = tick & ~mdc;
    assign fall_tick = tick & mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cmd_t             cmd_in,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_i,
    output logic             active,
    output kind_e            cur_kind,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic [DAT_W-1:0] rx_data,
    output logic             rx_err
);
    cmd_t              cmd_q;
    logic [FRM_W-1:0]  frame_q;
    logic [BCNT_W-1:0] bcnt;
    logic [POS_W-1:0]  pos;
    logic              in_frame;
    logic              last;
    logic              listen;
    logic              unused_seq;

    // Preamble and body have equal length, so the low counter bits index the body.
    assign pos      = ~bcnt[POS_W-1:0];
    assign in_frame = cmd_q.no_pre | bcnt[BCNT_W-1];
    assign last     = in_frame & (&bcnt[POS_W-1:0]);
    assign listen   = (cmd_q.kind == K_READ) && in_frame && (pos <= POS_W'(TA_HI));
    assign mdio_o   = in_frame ? frame_q[pos] : 1'b1;
    assign mdio_oe  = active & ~listen;
    assign done     = active & fall_tick & last;
    assign cur_kind = cmd_q.kind;
    assign unused_seq = ^{cmd_q.c45, cmd_q.port, cmd_q.dev, cmd_q.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cmd_q   <= '0;
            frame_q <= '0;
            bcnt    <= '0;
            rx_data <= '0;
            rx_err  <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            cmd_q   <= cmd_in;
            frame_q <= build_frame(cmd_in);
            bcnt    <= '0;
            rx_data <= '0;
            rx_err  <= 1'b0;
        end else if (active) begin
            if (rise_tick && listen) begin
                if (pos == POS_W'(TA_LO))
                    rx_err <= mdio_i;
                else if (pos < POS_W'(TA_LO))
                    rx_data <= {rx_data[DAT_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (last) active <= 1'b0;
                else      bcnt   <= bcnt + BCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0] div_q;
    logic             c45_q, err_q;
    logic [FLD_W-1:0] dev_q, port_q;
    logic             nopre_q, scan_q, pinc_q;
    logic [DAT_W-1:0] dat_q, adr_q;

    logic             busy, done, rx_err, data_busy;
    logic [DAT_W-1:0] rx_data;
    kind_e            cur_kind;
    logic             rise_t, fall_t;
    logic             wr_ok, start;
    cmd_t             cmd;
    logic             unused_bits;

    assign wr_ok       = bus_we & ~busy;
    assign data_busy   = busy & (cur_kind != K_ADDR);
    assign unused_bits = ^{bus_wdata[31:16], bus_wdata[13:12], bus_wdata[7], bus_wdata[5:0]};

    always_comb begin
        start       = 1'b0;
        cmd.kind    = K_WRITE;
        cmd.c45     = c45_q;
        cmd.no_pre  = nopre_q;
        cmd.port    = port_q;
        cmd.dev     = dev_q;
        cmd.data    = bus_wdata[DAT_W-1:0];
        if (wr_ok) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    cmd.port   = bus_wdata[2*FLD_W-1:FLD_W];
                    cmd.dev    = bus_wdata[FLD_W-1:0];
                    cmd.no_pre = bus_wdata[10];
                    cmd.kind   = K_READ;
                    cmd.data   = '0;
                    start      = bus_wdata[15];
                end
                OFS_DATA: start = 1'b1;
                OFS_ADDR: begin
                    cmd.kind = K_ADDR;
                    start    = c45_q;
                end
                default: start = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            c45_q   <= 1'b0;
            err_q   <= 1'b0;
            dev_q   <= '0;
            port_q  <= '0;
            nopre_q <= 1'b0;
            scan_q  <= 1'b0;
            pinc_q  <= 1'b0;
            dat_q   <= '0;
            adr_q   <= '0;
        end else begin
            if (wr_ok) begin
                unique case (bus_addr)
                    OFS_STAT: begin
                        div_q <= bus_wdata[15:8];
                        c45_q <= bus_wdata[6];
                    end
                    OFS_CTRL: begin
                        dev_q   <= bus_wdata[FLD_W-1:0];
                        port_q  <= bus_wdata[2*FLD_W-1:FLD_W];
                        nopre_q <= bus_wdata[10];
                        scan_q  <= bus_wdata[11];
                        pinc_q  <= bus_wdata[14];
                    end
                    OFS_DATA: dat_q <= bus_wdata[DAT_W-1:0];
                    OFS_ADDR: adr_q <= bus_wdata[DAT_W-1:0];
                    default: ;
                endcase
            end
            if (done && cur_kind == K_READ) begin
                dat_q <= rx_err ? '1 : rx_data;
                err_q <= rx_err;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STAT: bus_rdata = {16'b0, div_q, 1'b0, c45_q, 4'b0, err_q, busy};
            OFS_CTRL: bus_rdata = {16'b0, 1'b0, pinc_q, 2'b0, scan_q, nopre_q, port_q, dev_q};
            OFS_DATA: bus_rdata = {data_busy, 15'b0, dat_q};
            OFS_ADDR: bus_rdata = {16'b0, adr_q};
            default:  bus_rdata = '0;
        endcase
    end

    mdio_mgmt_clkgen u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_t),
        .fall_tick (fall_t)
    );

    mdio_mgmt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_in    (cmd),
        .rise_tick (rise_t),
        .fall_tick (fall_t),
        .mdio_i    (mdio_i),
        .active    (busy),
        .cur_kind  (cur_kind),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rx_data   (rx_data),
        .rx_err    (rx_err)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             data_busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             bus_we,
    input logic [3:0]       bus_addr,
    input logic [DAT_W-1:0] dat_q,
    input logic             err_q
);
    p_mdc_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_release_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    p_err_fill_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (dat_q == '1));

    p_data_busy_r9: assert property (@(posedge clk) disable iff (rst)
        data_busy |-> busy);

    p_busy_write_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && bus_we && bus_addr == OFS_DATA) |=> $stable(dat_q));

    p_out_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .data_busy (data_busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .dat_q     (dat_q),
    .err_q     (err_q)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd12;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int vecs = 0;
    int miss = 0;

    always #2 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Behavioural model of one frame: expected wire bits, MDC phase, busy and target reply.
    task automatic run_frame(input string req, input logic [3:0] waddr, input logic [31:0] wdata,
                             input bit pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] port, input logic [4:0] dev, input logic [15:0] fdata,
                             input bit rd, input bit bad_ta, input int half,
                             input bit dphase, input bit poke);
        logic [31:0] body;
        int nb, off, tot;
        body = {st, op, port, dev, 2'b10, fdata};
        nb   = pre ? 64 : 32;
        off  = pre ? 32 : 0;
        tot  = 2 * half * nb;
        @(negedge clk);
        bus_addr = waddr; bus_wdata = wdata; bus_we = 1'b1;
        @(posedge clk);
        for (int e = 0; e <= tot; e++) begin
            bit  ebusy, emdc, eoe, ebit, inb;
            int  b, p;
            @(negedge clk);
            bus_we   = 1'b0;
            bus_addr = (e == 1) ? 4'd14 : 4'd12;
            #1;
            ebusy = (e < tot);
            emdc  = ebusy && (((e / half) % 2) == 1);
            b     = e / (2 * half);
            inb   = ebusy && (b >= off);
            p     = inb ? 31 - (b - off) : 99;
            ebit  = inb ? body[p] : 1'b1;
            eoe   = ebusy && !(rd && inb && p <= 17);
            chk("R2", "mdc", {31'b0, mdc}, {31'b0, emdc});
            chk("R4", "mdio_oe", {31'b0, mdio_oe}, {31'b0, eoe});
            if (eoe) chk(req, $sformatf("bit %0d", b), {31'b0, mdio_o}, {31'b0, ebit});
            if (e == 1) chk("R9", "data busy bit", {31'b0, bus_rdata[31]}, {31'b0, dphase});
            else        chk("R9", "status busy", {31'b0, bus_rdata[0]}, {31'b0, ebusy});
            if (rd && inb && p == 16)     mdio_i = bad_ta;
            else if (rd && inb && p < 16) mdio_i = fdata[p];
            else                          mdio_i = 1'b1;
            if (poke && e == 3) begin
                bus_addr = 4'd14; bus_wdata = 32'h0000_1111; bus_we = 1'b1;
            end
        end
        bus_addr = 4'd12;
        mdio_i   = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 12; a < 16; a++) begin
            reg_rd(4'(a), v);
            chk("R1", $sformatf("reset word %0d", a), v, 32'h0);
        end
        chk("R2", "mdc idle", {31'b0, mdc}, 32'h0);
        chk("R4", "oe idle", {31'b0, mdio_oe}, 32'h0);

        // R1 register layout and flags
        reg_wr(4'd12, 32'h0000_0200);
        reg_rd(4'd12, v); chk("R1", "status readback", v, 32'h0000_0200);
        reg_wr(4'd13, 32'h0000_48A3);
        reg_rd(4'd13, v); chk("R1", "control readback", v, 32'h0000_48A3);
        chk("R1", "flags start nothing", {31'b0, mdc}, 32'h0);

        // R3 Clause 22 write, half period 2
        run_frame("R3", 4'd14, 32'h0000_A5C3, 1, 2'b01, 2'b01, 5'd5, 5'd3, 16'hA5C3, 0, 0, 2, 1, 0);
        reg_rd(4'd14, v); chk("R3", "data after write", v, 32'h0000_A5C3);

        // R4 Clause 22 read
        run_frame("R4", 4'd13, 32'h0000_8022, 1, 2'b01, 2'b10, 5'd1, 5'd2, 16'h1234, 1, 0, 2, 1, 0);
        reg_rd(4'd14, v); chk("R4", "read data", v, 32'h0000_1234);
        reg_rd(4'd12, v); chk("R8", "no error", {31'b0, v[1]}, 32'h0);

        // R8 read error
        run_frame("R8", 4'd13, 32'h0000_8022, 1, 2'b01, 2'b10, 5'd1, 5'd2, 16'h0F0F, 1, 1, 2, 1, 0);
        reg_rd(4'd14, v); chk("R8", "error data", v, 32'h0000_FFFF);
        reg_rd(4'd12, v); chk("R8", "error flag", {31'b0, v[1]}, 32'h1);

        // R5 address write ignored in Clause 22 mode
        reg_wr(4'd15, 32'h0000_0077);
        repeat (4) begin
            reg_rd(4'd12, v);
            chk("R5", "no frame in c22", {31'b0, v[0]}, 32'h0);
            chk("R5", "mdc quiet", {31'b0, mdc}, 32'h0);
        end
        reg_rd(4'd15, v); chk("R5", "address stored", v, 32'h0000_0077);

        // R5 Clause 45 address frame, half period 3
        reg_wr(4'd12, 32'h0000_0340);
        reg_wr(4'd13, 32'h0000_00E1);
        run_frame("R5", 4'd15, 32'h0000_00AB, 1, 2'b00, 2'b00, 5'd7, 5'd1, 16'h00AB, 0, 0, 3, 0, 0);

        // R6 Clause 45 write with an injected write mid-frame (R10)
        run_frame("R6", 4'd14, 32'h0000_BEEF, 1, 2'b00, 2'b01, 5'd7, 5'd1, 16'hBEEF, 0, 0, 3, 1, 1);
        reg_rd(4'd14, v); chk("R10", "busy write ignored", v, 32'h0000_BEEF);

        // R7 Clause 45 read, no preamble, divider 0 (half period 1)
        reg_wr(4'd12, 32'h0000_0040);
        run_frame("R7", 4'd13, 32'h0000_84E1, 0, 2'b00, 2'b11, 5'd7, 5'd1, 16'h5A5A, 1, 0, 1, 1, 0);
        reg_rd(4'd14, v); chk("R6", "c45 read data", v, 32'h0000_5A5A);
        reg_rd(4'd12, v); chk("R8", "error cleared", {31'b0, v[1]}, 32'h0);

        summary();
        $finish;
    end
endmodule